// File: doc/BRIEF.md
# Fixed-Priority Bus Arbiter with Ownership Lock

This block decides which of several masters owns a shared on-chip bus. Each master raises a request line, and the arbiter answers with a one-hot grant. When more than one master is requesting, the lowest-indexed requester wins. A grant is registered, so it appears one clock after the arbitration decision. Once a master holds the bus, the grant stays put until a completion strobe marks the end of the current transaction. Only then does the arbiter choose again.

A master that holds the grant can raise its own lock line. While that lock is up, the arbiter keeps the bus with that master. It then ignores completion strobes, requests from every other master, lock lines from masters that do not own the bus, and even the owner's own request. This lets a master run several transfers back to back with nothing in between, for example a read followed by a write that together form a test-and-set on a shared flag. When the owner drops its lock, its tenure ends and the arbiter chooses again among the masters requesting at that moment. Other masters simply keep their requests raised while they wait.

The controller has three named states:
- IDLE: no master owns the bus.
- OWNED: a master holds the grant with no lock.
- LOCKED: the owner holds the grant under lock.

The transitions are:
- IDLE→OWNED when any request is present.
- OWNED→LOCKED when the owner's lock is high.
- OWNED→OWNED or OWNED→IDLE on a completion strobe without lock, depending on whether anyone is requesting.
- LOCKED→OWNED or LOCKED→IDLE when the owner releases its lock, again depending on whether anyone is requesting.

Top module: `bus_lock_arbiter`

## Requirements
- R1: During and right after reset, no grant bit is set and the arbiter is in IDLE.
- R2: At most one bit of grant_o is set in any cycle.
- R3: From IDLE, if any request is present, the next cycle grants the requester with the lowest index (bit 0 has the highest priority).
- R4: While a master owns the bus without lock and done_i is low, grant_o does not change, even when higher-priority requests appear.
- R5: When done_i is high and the owner's lock is low, the next cycle grants the lowest-indexed requester, which may be the current owner. If nobody is requesting, grant_o becomes all zero.
- R6: While the owner's lock bit is high, grant_o does not change on the next cycle, whatever the values of done_i and the other masters' requests.
- R7: A lock bit from a master that does not hold the grant has no effect: in IDLE it neither blocks nor takes a grant, and in OWNED it neither holds off re-arbitration on done_i nor freezes the grant.
- R8: A locked owner that drops its request keeps its grant for as long as its lock bit stays high.
- R9: When a locked owner drops its lock, the next cycle grants the lowest-indexed requester present in that cycle, or all zero if none is present.
- R10: A newly granted bit always belongs to a master whose request was high in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | N_MASTERS | Request per master; bit 0 has the highest priority |
| lock_i | input | N_MASTERS | Lock per master; acted on only when that master holds the grant |
| done_i | input | 1 | Completion strobe for the current transaction |
| grant_o | output | N_MASTERS | Registered one-hot grant, or all zero when the bus is free |

## Verification
The assertions assume the following about the inputs:
- All inputs change only between rising edges.
- A master that wants the bus keeps its request high until it is granted, so a grant always traces back to a request sampled one cycle earlier.
- The lock and done inputs are meaningful only relative to the current owner.

The stimulus drives every input on the falling edge. With four masters, it sweeps every owner against every 4-bit pattern of competing requests. It also sets lock bits on owners and on non-owners alike, so the filtering of lock to the owner is exercised rather than assumed.

// File: rtl/lockarb_pkg.sv
package lockarb_pkg;

    // Arbiter tenure states
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_OWNED  = 2'd1,
        ST_LOCKED = 2'd2
    } arb_state_e;

endpackage

// File: rtl/lockarb_prio_pick.sv
// Fixed-priority picker: the lowest set index wins.
module lockarb_prio_pick #(
    parameter int N = 4
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] pick,
    output logic         any
);

    logic [N:0] seen;

    assign seen[0] = 1'b0;

    generate
        for (genvar i = 0; i < N; i++) begin : g_chain
            assign pick[i]   = req[i] & ~seen[i];
            assign seen[i+1] = seen[i] | req[i];
        end
    endgenerate

    assign any = seen[N];

endmodule

// File: rtl/lockarb_owner_lock.sv
// Reduces the lock lines to the one belonging to the current owner.
module lockarb_owner_lock #(
    parameter int N = 4
) (
    input  logic [N-1:0] grant,
    input  logic [N-1:0] lock,
    output logic         owner_locked
);

    logic [N-1:0] masked;

    generate
        for (genvar i = 0; i < N; i++) begin : g_mask
            assign masked[i] = grant[i] & lock[i];
        end
    endgenerate

    assign owner_locked = |masked;

endmodule

// File: rtl/bus_lock_arbiter.sv
module bus_lock_arbiter #(
    parameter int N_MASTERS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_MASTERS-1:0] req_i,
    input  logic [N_MASTERS-1:0] lock_i,
    input  logic                 done_i,
    output logic [N_MASTERS-1:0] grant_o
);

    import lockarb_pkg::*;

    localparam logic [N_MASTERS-1:0] NO_GRANT = '0;

    arb_state_e           state_q, state_d;
    logic [N_MASTERS-1:0] grant_q, grant_d;
    logic [N_MASTERS-1:0] winner;
    logic                 any_req;
    logic                 owner_locked;
    logic                 rearb;

    lockarb_prio_pick #(.N(N_MASTERS)) u_pick (
        .req  (req_i),
        .pick (winner),
        .any  (any_req)
    );

    lockarb_owner_lock #(.N(N_MASTERS)) u_olock (
        .grant        (grant_q),
        .lock         (lock_i),
        .owner_locked (owner_locked)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            grant_q <= NO_GRANT;
        end else begin
            state_q <= state_d;
            grant_q <= grant_d;
        end
    end

    // Transition logic
    always_comb begin
        state_d = state_q;
        rearb   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (any_req) begin
                    rearb   = 1'b1;
                    state_d = ST_OWNED;
                end
            end
            ST_OWNED: begin
                if (owner_locked) begin
                    state_d = ST_LOCKED;
                end else if (done_i) begin
                    rearb   = 1'b1;
                    state_d = any_req ? ST_OWNED : ST_IDLE;
                end
            end
            ST_LOCKED: begin
                if (!owner_locked) begin
                    rearb   = 1'b1;
                    state_d = any_req ? ST_OWNED : ST_IDLE;
                end
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // Output logic
    always_comb begin
        grant_d = grant_q;
        if (rearb) begin
            grant_d = winner;
        end
        if (state_d == ST_IDLE) begin
            grant_d = NO_GRANT;
        end
    end

    assign grant_o = grant_q;

endmodule

// File: rtl/lockarb_chk.sv
module lockarb_chk #(
    parameter int N = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [N-1:0]            req_i,
    input logic [N-1:0]            lock_i,
    input logic                    done_i,
    input logic [N-1:0]            grant_o,
    input lockarb_pkg::arb_state_e state_q
);

    import lockarb_pkg::*;

    // R2
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o));

    // R4
    owned_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OWNED && !done_i) |=> $stable(grant_o));

    // R6
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(lock_i & grant_o)) |=> $stable(grant_o));

    // R9
    release_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOCKED && !(|(lock_i & grant_o)) && req_i == '0)
        |=> (grant_o == '0));

    // R10
    grant_to_requester_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o != $past(grant_o) && grant_o != '0)
        |-> (|(grant_o & $past(req_i))));

endmodule

bind bus_lock_arbiter lockarb_chk #(.N(N_MASTERS)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_i   (req_i),
    .lock_i  (lock_i),
    .done_i  (done_i),
    .grant_o (grant_o),
    .state_q (state_q)
);

// File: tb/sim_bus_lock_arbiter.sv
module sim_bus_lock_arbiter;

    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [N-1:0] req, lock, grant;
    logic         done;
    int           n_run = 0;
    int           n_fail = 0;

    always #5 clk = ~clk;

    bus_lock_arbiter #(.N_MASTERS(N)) u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (req),
        .lock_i  (lock),
        .done_i  (done),
        .grant_o (grant)
    );

    function automatic logic [N-1:0] lowest(input logic [N-1:0] p);
        return p & (~p + 1'b1);
    endfunction

    function automatic logic [N-1:0] bit_of(input int o);
        logic [N-1:0] r;
        r = '0;
        r[o] = 1'b1;
        return r;
    endfunction

    task automatic check(input string tag, input logic [N-1:0] exp);
        n_run++;
        if (grant !== exp) begin
            n_fail++;
            $display("FAIL %s grant=%b expected=%b", tag, grant, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic drive(input logic [N-1:0] r, input logic [N-1:0] l, input logic d);
        req  = r;
        lock = l;
        done = d;
    endtask

    task automatic go_idle();
        drive('0, '0, 1'b1);
        tick();
        drive('0, '0, 1'b0);
        tick();
    endtask

    task automatic take(input int o);
        go_idle();
        drive(bit_of(o), '0, 1'b0);
        tick();
        check("R3 take", bit_of(o));
    endtask

    initial begin
        rst_n = 1'b0;
        drive('0, '0, 1'b0);
        repeat (3) tick();
        check("R1 in reset", '0);
        rst_n = 1'b1;
        tick();
        check("R1 after reset", '0);

        // R3: priority from IDLE
        for (int p = 1; p < (1 << N); p++) begin
            go_idle();
            drive(N'(p), '0, 1'b0);
            tick();
            check("R3 idle pick", lowest(N'(p)));
        end

        // R4 hold, R5 re-arbitration on done
        for (int o = 0; o < N; o++) begin
            for (int p = 0; p < (1 << N); p++) begin
                take(o);
                drive(N'(p) | bit_of(o), '0, 1'b0);
                tick();
                check("R4 hold", bit_of(o));
                drive(N'(p), '0, 1'b1);
                tick();
                check("R5 done pick", lowest(N'(p)));
            end
        end

        // R6 lock hold, R7 foreign lock, R8 dropped request, R9 release
        for (int o = 0; o < N; o++) begin
            for (int p = 0; p < (1 << N); p++) begin
                take(o);
                drive(bit_of(o), bit_of(o), 1'b0);
                tick();
                check("R6 lock enter", bit_of(o));
                drive(N'(p) | bit_of(o), '1, 1'b1);
                tick();
                check("R6 lock hold", bit_of(o));
                drive(N'(p) & ~bit_of(o), bit_of(o), 1'b1);
                tick();
                check("R8 no req", bit_of(o));
                drive(N'(p), '0, 1'b0);
                tick();
                check("R9 release", lowest(N'(p)));
            end
        end

        // R7: lock from non-owners while OWNED
        for (int o = 0; o < N; o++) begin
            for (int p = 0; p < (1 << N); p++) begin
                take(o);
                drive(N'(p) | bit_of(o), ~bit_of(o), 1'b0);
                tick();
                check("R7 foreign hold", bit_of(o));
                drive(N'(p), ~bit_of(o), 1'b1);
                tick();
                check("R7 foreign done", lowest(N'(p)));
            end
        end

        // R7: lock while IDLE
        go_idle();
        drive('0, '1, 1'b0);
        tick();
        check("R7 idle lock", '0);
        for (int p = 1; p < (1 << N); p++) begin
            go_idle();
            drive(N'(p), '1, 1'b0);
            tick();
            check("R7 idle lock pick", lowest(N'(p)));
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule